// File: doc/BRIEF.md
# Next-PC and Jump Resolution Unit

This block decides where the instruction stream of a 32-bit integer core goes next. For the instruction it is given, it produces one of three results: the sequential address, a redirect to a branch or jump target, or an instruction-address-misaligned exception. It also produces the value that a jump-and-link or an add-upper-immediate-to-PC writes back to rd. The six conditional branch comparisons are resolved inside the block, from the two register operands and the funct3 condition code.

The execute stage feeds it the current PC, both source operands, an already decoded and sign-extended immediate, and one strobe for each kind of control instruction. All results are registered, so they appear on the outputs one clock after the inputs are presented. A high redirect tells the fetch side to discard the instruction behind the transfer, because there are no delay slots. A high exception flag tells the trap logic that the transfer must not happen. In that case the offending target is left on the next-PC output so that it can be reported.

Top module: `pc_redirect_unit`

## Requirements
- R1: While rst_n is low, next_pc_o, rd_val_o, redirect_o and misalign_o are all zero.
- R2: Every result appears on the outputs at the first rising clock edge after the inputs that produced it have been sampled, which gives a latency of one cycle.
- R3: With is_branch_i high, cond_i selects the comparison of rs1_i against rs2_i. The codes are 3'b000 equal, 3'b001 not equal, 3'b100 signed less than, 3'b101 signed greater or equal, 3'b110 unsigned less than and 3'b111 unsigned greater or equal. A taken branch with an aligned target gives next_pc_o = pc_i + imm_i, redirect_o = 1 and rd_val_o = 0.
- R4: The condition codes 3'b010 and 3'b011 never take a branch, whatever the operands are.
- R5: When is_jal_i is high, the target is pc_i + imm_i and rd_val_o = pc_i + 4. If that target is aligned, redirect_o = 1.
- R6: When is_jalr_i is high, the target is rs1_i + imm_i with bit 0 forced to 0, and rd_val_o = pc_i + 4. If that target is aligned, redirect_o = 1.
- R7: When a taken branch or a jump produces a target whose bits [1:0] are not both zero, misalign_o = 1 and redirect_o = 0, and next_pc_o carries that target.
- R8: A branch that is not taken gives next_pc_o = pc_i + 4 with redirect_o = 0 and misalign_o = 0, even when its target is misaligned.
- R9: When is_auipc_i is high and no jump strobe is set, rd_val_o = pc_i + (imm_i with bits [11:0] treated as zero). The low 12 bits of imm_i have no effect. next_pc_o = pc_i + 4 and redirect_o = 0.
- R10: When no strobe is set, next_pc_o = pc_i + 4, redirect_o = 0, misalign_o = 0 and rd_val_o = 0.
- R11: When several strobes are set at once, JALR takes priority over JAL, and JAL takes priority over a branch. A jump's link value takes priority over the AUIPC sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | Address of the current instruction |
| rs1_i | input | 32 | First source operand |
| rs2_i | input | 32 | Second source operand |
| imm_i | input | 32 | Decoded, sign-extended immediate |
| cond_i | input | 3 | Branch condition code (funct3) |
| is_branch_i | input | 1 | Instruction is a conditional branch |
| is_jal_i | input | 1 | Instruction is a PC-relative jump and link |
| is_jalr_i | input | 1 | Instruction is a register-indirect jump and link |
| is_auipc_i | input | 1 | Instruction adds an upper immediate to the PC |
| next_pc_o | output | 32 | Next fetch address, or the faulting target |
| redirect_o | output | 1 | A transfer is taken; flush the following instruction |
| rd_val_o | output | 32 | Link value or AUIPC sum for rd |
| misalign_o | output | 1 | Instruction-address-misaligned exception |

## Verification
The comparisons are tried with operand pairs that separate the signed and unsigned orderings: equal values, small positives in both orders, all-ones against one, and the most negative value against the most positive. Each of these pairs flips at least one pair of conditions that would otherwise agree. Jump targets are tried with positive and negative offsets, and with register sums whose bit 0 is set, so that clearing bit 0 shows up as a different address and the alignment test sees bit 1 on its own. Misaligned targets are applied to taken branches, to branches that are not taken, and to both jump kinds, which shows that the exception depends on whether the transfer is taken and not only on the target. An AUIPC with nonzero low immediate bits, together with mixed strobes, checks that the low immediate bits are ignored and that the priority order holds.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    // Branch condition codes (funct3 of a conditional branch)
    typedef enum logic [2:0] {
        BR_EQ  = 3'b000,
        BR_NE  = 3'b001,
        BR_LT  = 3'b100,
        BR_GE  = 3'b101,
        BR_LTU = 3'b110,
        BR_GEU = 3'b111
    } br_cond_e;

    // Which transfer, if any, the current instruction performs
    typedef enum logic [1:0] {
        XFER_NONE,
        XFER_BRANCH,
        XFER_JAL,
        XFER_JALR
    } xfer_e;

endpackage

// File: rtl/pcu_branch_cmp.sv
module pcu_branch_cmp #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [2:0]   cond_i,
    output logic         take_o
);
    import pcu_pkg::*;

    logic [W:0] diff;
    logic       eq;
    logic       ult;
    logic       slt;

    always_comb begin
        // one subtractor gives the unsigned order through its borrow
        diff = {1'b0, a_i} - {1'b0, b_i};
        eq   = (a_i == b_i);
        ult  = diff[W];
        // when the signs differ, the negative operand is the smaller one
        slt  = (a_i[W-1] ^ b_i[W-1]) ? a_i[W-1] : ult;

        case (cond_i)
            BR_EQ:   take_o = eq;
            BR_NE:   take_o = !eq;
            BR_LT:   take_o = slt;
            BR_GE:   take_o = !slt;
            BR_LTU:  take_o = ult;
            BR_GEU:  take_o = !ult;
            default: take_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pcu_target_gen.sv
module pcu_target_gen #(
    parameter int unsigned W          = 32,
    parameter int unsigned INSN_BYTES = 4,
    parameter int unsigned UPPER_LSB  = 12
) (
    input  logic [W-1:0] pc_i,
    input  logic [W-1:0] rs1_i,
    input  logic [W-1:0] imm_i,
    output logic [W-1:0] rel_tgt_o,
    output logic [W-1:0] reg_tgt_o,
    output logic [W-1:0] link_o,
    output logic [W-1:0] upper_o
);
    localparam logic [W-1:0] STEP     = W'(INSN_BYTES);
    localparam logic [W-1:0] LSB_MASK = ~W'(1);

    logic [W-1:0] reg_sum;
    logic [W-1:0] upper_imm;

    always_comb begin
        rel_tgt_o = pc_i + imm_i;
        reg_sum   = rs1_i + imm_i;
        reg_tgt_o = reg_sum & LSB_MASK;
        link_o    = pc_i + STEP;
        upper_imm = {imm_i[W-1:UPPER_LSB], {UPPER_LSB{1'b0}}};
        upper_o   = pc_i + upper_imm;
    end

endmodule

// File: rtl/pcu_align_chk.sv
module pcu_align_chk #(
    parameter int unsigned ALIGN_BYTES = 4,
    localparam int unsigned AB   = $clog2(ALIGN_BYTES),
    localparam int unsigned LSBW = (AB > 0) ? AB : 1
) (
    input  logic [LSBW-1:0] lsb_i,
    output logic            misal_o
);
    generate
        if (AB == 0) begin : g_none
            assign misal_o = 1'b0;
        end else begin : g_chk
            assign misal_o = |lsb_i;
        end
    endgenerate

endmodule

// File: rtl/pc_redirect_unit.sv
module pc_redirect_unit #(
    parameter int unsigned XLEN        = 32,
    parameter int unsigned ALIGN_BYTES = 4,
    parameter int unsigned INSN_BYTES  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] rs1_i,
    input  logic [XLEN-1:0] rs2_i,
    input  logic [XLEN-1:0] imm_i,
    input  logic [2:0]      cond_i,
    input  logic            is_branch_i,
    input  logic            is_jal_i,
    input  logic            is_jalr_i,
    input  logic            is_auipc_i,
    output logic [XLEN-1:0] next_pc_o,
    output logic            redirect_o,
    output logic [XLEN-1:0] rd_val_o,
    output logic            misalign_o
);
    import pcu_pkg::*;

    localparam int unsigned AB   = $clog2(ALIGN_BYTES);
    localparam int unsigned LSBW = (AB > 0) ? AB : 1;

    typedef struct packed {
        logic [XLEN-1:0] next_pc;
        logic            redirect;
        logic [XLEN-1:0] rd_val;
        logic            misalign;
    } pcu_state_t;

    pcu_state_t st_d, st_q;

    logic            br_take;
    logic [XLEN-1:0] rel_tgt;
    logic [XLEN-1:0] reg_tgt;
    logic [XLEN-1:0] link_val;
    logic [XLEN-1:0] upper_val;
    logic            rel_misal;
    logic            reg_misal;
    xfer_e           xfer;
    logic [XLEN-1:0] tgt;
    logic            tgt_bad;

    pcu_branch_cmp #(.W(XLEN)) u_cmp (
        .a_i    (rs1_i),
        .b_i    (rs2_i),
        .cond_i (cond_i),
        .take_o (br_take)
    );

    pcu_target_gen #(.W(XLEN), .INSN_BYTES(INSN_BYTES), .UPPER_LSB(12)) u_tgt (
        .pc_i      (pc_i),
        .rs1_i     (rs1_i),
        .imm_i     (imm_i),
        .rel_tgt_o (rel_tgt),
        .reg_tgt_o (reg_tgt),
        .link_o    (link_val),
        .upper_o   (upper_val)
    );

    pcu_align_chk #(.ALIGN_BYTES(ALIGN_BYTES)) u_rel_align (
        .lsb_i   (rel_tgt[LSBW-1:0]),
        .misal_o (rel_misal)
    );

    pcu_align_chk #(.ALIGN_BYTES(ALIGN_BYTES)) u_reg_align (
        .lsb_i   (reg_tgt[LSBW-1:0]),
        .misal_o (reg_misal)
    );

    always_comb begin
        // resolve which transfer wins: register jump, relative jump, taken branch
        if (is_jalr_i)                  xfer = XFER_JALR;
        else if (is_jal_i)              xfer = XFER_JAL;
        else if (is_branch_i && br_take) xfer = XFER_BRANCH;
        else                            xfer = XFER_NONE;

        tgt     = (xfer == XFER_JALR) ? reg_tgt : rel_tgt;
        tgt_bad = (xfer == XFER_JALR) ? reg_misal : rel_misal;

        st_d.next_pc  = link_val;
        st_d.redirect = 1'b0;
        st_d.misalign = 1'b0;
        st_d.rd_val   = '0;

        if (xfer != XFER_NONE) begin
            st_d.next_pc = tgt;
            if (tgt_bad) st_d.misalign = 1'b1;
            else         st_d.redirect = 1'b1;
        end

        if (is_jal_i || is_jalr_i) st_d.rd_val = link_val;
        else if (is_auipc_i)       st_d.rd_val = upper_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign next_pc_o  = st_q.next_pc;
    assign redirect_o = st_q.redirect;
    assign rd_val_o   = st_q.rd_val;
    assign misalign_o = st_q.misalign;

endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
    parameter int unsigned XLEN        = 32,
    parameter int unsigned ALIGN_BYTES = 4,
    parameter int unsigned INSN_BYTES  = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] pc_i,
    input logic            is_branch_i,
    input logic            is_jal_i,
    input logic            is_jalr_i,
    input logic [XLEN-1:0] next_pc_o,
    input logic            redirect_o,
    input logic [XLEN-1:0] rd_val_o,
    input logic            misalign_o
);
    localparam logic [XLEN-1:0] MASK = XLEN'(ALIGN_BYTES - 1);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R7
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(redirect_o && misalign_o));

    // R7
    aligned_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> ((next_pc_o & MASK) == '0));

    // R7
    misalign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_o |-> ((next_pc_o & MASK) != '0));

    // R8
    seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (!redirect_o && !misalign_o) |-> (next_pc_o == $past(pc_i) + STEP));

    // R5
    link_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(is_jal_i || is_jalr_i) |-> (rd_val_o == $past(pc_i) + STEP));

    // R10
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(!is_jal_i && !is_jalr_i && !is_branch_i) |-> (!redirect_o && !misalign_o));

endmodule

bind pc_redirect_unit pcu_checker #(
    .XLEN(XLEN), .ALIGN_BYTES(ALIGN_BYTES), .INSN_BYTES(INSN_BYTES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pc_i        (pc_i),
    .is_branch_i (is_branch_i),
    .is_jal_i    (is_jal_i),
    .is_jalr_i   (is_jalr_i),
    .next_pc_o   (next_pc_o),
    .redirect_o  (redirect_o),
    .rd_val_o    (rd_val_o),
    .misalign_o  (misalign_o)
);

// File: tb/pc_redirect_unit_bench.sv
module pc_redirect_unit_bench;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_i = '0, rs1_i = '0, rs2_i = '0, imm_i = '0;
    logic [2:0]  cond_i = '0;
    logic        is_branch_i = 1'b0, is_jal_i = 1'b0, is_jalr_i = 1'b0, is_auipc_i = 1'b0;
    logic [31:0] next_pc_o, rd_val_o;
    logic        redirect_o, misalign_o;

    int checks = 0;
    int fails  = 0;

    always #(PERIOD/2) clk = ~clk;

    pc_redirect_unit u_pc_redirect_unit (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .rs1_i(rs1_i), .rs2_i(rs2_i),
        .imm_i(imm_i), .cond_i(cond_i), .is_branch_i(is_branch_i),
        .is_jal_i(is_jal_i), .is_jalr_i(is_jalr_i), .is_auipc_i(is_auipc_i),
        .next_pc_o(next_pc_o), .redirect_o(redirect_o), .rd_val_o(rd_val_o),
        .misalign_o(misalign_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // expected outcome of a branch, from signed/unsigned compares of the bench
    function automatic logic ref_take(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
        case (c)
            3'b000: return a == b;
            3'b001: return a != b;
            3'b100: return $signed(a) <  $signed(b);
            3'b101: return $signed(a) >= $signed(b);
            3'b110: return a <  b;
            3'b111: return a >= b;
            default: return 1'b0;
        endcase
    endfunction

    // present one instruction at a falling edge; results are read after the next rising edge
    task automatic issue(input logic [31:0] pc, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] imm, input logic [2:0] c,
                         input logic br, input logic jal, input logic jalr, input logic aui);
        @(negedge clk);
        pc_i = pc; rs1_i = a; rs2_i = b; imm_i = imm; cond_i = c;
        is_branch_i = br; is_jal_i = jal; is_jalr_i = jalr; is_auipc_i = aui;
        @(posedge clk);
        #(PERIOD/4);
    endtask

    task automatic expect_out(input string req, input logic [31:0] npc, input logic rdr,
                              input logic [31:0] rdv, input logic mis);
        check(req, "next_pc", next_pc_o, npc);
        check(req, "redirect", {31'b0, redirect_o}, {31'b0, rdr});
        check(req, "rd_val", rd_val_o, rdv);
        check(req, "misalign", {31'b0, misalign_o}, {31'b0, mis});
    endtask

    task automatic t_reset();
        // R1: outputs cleared while reset is held, even with a jump presented
        rst_n = 1'b0;
        issue(32'h100, 0, 0, 32'h40, 0, 0, 1, 0, 0);
        expect_out("R1", 32'h0, 1'b0, 32'h0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_latency();
        // R2: output reflects the previous edge's inputs, not the new ones
        issue(32'h200, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        pc_i = 32'h300;
        #1;
        check("R2", "next_pc holds until edge", next_pc_o, 32'h204);
        @(posedge clk);
        #(PERIOD/4);
        check("R2", "next_pc after edge", next_pc_o, 32'h304);
    endtask

    task automatic t_branches();
        logic [31:0] pa [6] = '{32'h5, 32'h3, 32'h7, 32'hFFFF_FFFF, 32'h1, 32'h8000_0000};
        logic [31:0] pb [6] = '{32'h5, 32'h7, 32'h3, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF};
        logic [2:0]  cc [6] = '{3'b000, 3'b001, 3'b100, 3'b101, 3'b110, 3'b111};
        for (int p = 0; p < 6; p++) begin
            for (int k = 0; k < 6; k++) begin
                logic t;
                t = ref_take(cc[k], pa[p], pb[p]);
                issue(32'h8000, pa[p], pb[p], 32'h40, cc[k], 1, 0, 0, 0);
                if (t) expect_out("R3", 32'h8040, 1'b1, 32'h0, 1'b0);
                else   expect_out("R8", 32'h8004, 1'b0, 32'h0, 1'b0);
            end
        end
        // R4: unused codes never take, for several orderings
        for (int p = 0; p < 6; p++) begin
            issue(32'h8000, pa[p], pb[p], 32'h40, 3'b010, 1, 0, 0, 0);
            expect_out("R4", 32'h8004, 1'b0, 32'h0, 1'b0);
            issue(32'h8000, pa[p], pb[p], 32'h40, 3'b011, 1, 0, 0, 0);
            expect_out("R4", 32'h8004, 1'b0, 32'h0, 1'b0);
        end
    endtask

    task automatic t_jal();
        // R5: forward and backward offsets
        issue(32'h1000, 0, 0, 32'h100, 0, 0, 1, 0, 0);
        expect_out("R5", 32'h1100, 1'b1, 32'h1004, 1'b0);
        issue(32'h2000, 0, 0, 32'hFFFF_FFF8, 0, 0, 1, 0, 0);
        expect_out("R5", 32'h1FF8, 1'b1, 32'h2004, 1'b0);
    endtask

    task automatic t_jalr();
        // R6: bit 0 of the sum is cleared
        issue(32'h500, 32'h4001, 0, 32'h10, 0, 0, 0, 1, 0);
        expect_out("R6", 32'h4010, 1'b1, 32'h504, 1'b0);
        issue(32'h600, 32'h4005, 0, 32'hFFFF_FFFF, 0, 0, 0, 1, 0);
        expect_out("R6", 32'h4004, 1'b1, 32'h604, 1'b0);
    endtask

    task automatic t_misalign();
        // R7: taken branch to pc+6
        issue(32'h8000, 32'h9, 32'h9, 32'h6, 3'b000, 1, 0, 0, 0);
        expect_out("R7", 32'h8006, 1'b0, 32'h0, 1'b1);
        // R8: same target, branch not taken, no exception
        issue(32'h8000, 32'h9, 32'h9, 32'h6, 3'b001, 1, 0, 0, 0);
        expect_out("R8", 32'h8004, 1'b0, 32'h0, 1'b0);
        // R7: relative jump to an address with bit 1 set
        issue(32'h100, 0, 0, 32'h2, 0, 0, 1, 0, 0);
        expect_out("R7", 32'h102, 1'b0, 32'h104, 1'b1);
        // R7: register jump, 0x3001+2 = 0x3003 -> 0x3002, bit 1 set
        issue(32'h700, 32'h3001, 0, 32'h2, 0, 0, 0, 1, 0);
        expect_out("R7", 32'h3002, 1'b0, 32'h704, 1'b1);
    endtask

    task automatic t_auipc();
        // R9: low 12 immediate bits are ignored
        issue(32'h1000, 0, 0, 32'h1234_5FFF, 0, 0, 0, 0, 1);
        expect_out("R9", 32'h1004, 1'b0, 32'h1234_6000, 1'b0);
        issue(32'h1000, 0, 0, 32'h1234_5000, 0, 0, 0, 0, 1);
        expect_out("R9", 32'h1004, 1'b0, 32'h1234_6000, 1'b0);
    endtask

    task automatic t_idle();
        // R10
        issue(32'h50, 32'h1, 32'h1, 32'h80, 3'b000, 0, 0, 0, 0);
        expect_out("R10", 32'h54, 1'b0, 32'h0, 1'b0);
    endtask

    task automatic t_priority();
        // R11: register jump beats relative jump
        issue(32'h100, 32'h9000, 0, 32'h20, 0, 0, 1, 1, 0);
        expect_out("R11", 32'h9020, 1'b1, 32'h104, 1'b0);
        // R11: relative jump beats a branch that is not taken
        issue(32'h100, 32'h1, 32'h2, 32'h20, 3'b000, 1, 1, 0, 0);
        expect_out("R11", 32'h120, 1'b1, 32'h104, 1'b0);
        // R11: link value beats the AUIPC sum
        issue(32'h100, 0, 0, 32'h0000_1000, 0, 0, 1, 0, 1);
        expect_out("R11", 32'h1100, 1'b1, 32'h104, 1'b0);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_branches();
        t_jal();
        t_jalr();
        t_misalign();
        t_auipc();
        t_idle();
        t_priority();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule